// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a byte-oriented I2C target that lets an external bus controller read and write a bank of 8-bit registers. SCL and SDA arrive as asynchronous pins and are oversampled on a fast system clock through two-flop synchronizers. SDA is driven only through an open-drain pull-low enable. The 7-bit bus address is fixed except for one bit, which is taken from a strap input.

A write transfer sends the address with the direction bit clear. It is followed by a register-index byte and then any number of data bytes. Each data byte reaches the register bank as a single-cycle write strobe. A read transfer first sets the index with a write, then issues a repeated START with the direction bit set. The slave then returns bytes until the controller declines one. The top bit of the index byte selects whether the index advances after every byte or stays fixed. Clock stretching, general call and 10-bit addressing are not supported.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The slave answers only the 7-bit address 0011100 when `addr_strap` is low and 0011110 when it is high. On any other address it leaves SDA released and performs no register write until the next START.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a STOP the slave releases SDA and ignores bus activity until a START.
- R3: The slave pulls SDA low during the ninth clock after its matching address byte, after the index byte and after every write data byte.
- R4: The first byte after a write-direction address is the index byte. Bits 6:0 give the register index and bit 7 set enables auto-increment. Bytes on the bus are most significant bit first, and the address byte carries the direction in bit 0, with 1 meaning read.
- R5: Every write data byte produces exactly one single-cycle `reg_we` pulse, with `reg_addr` equal to the current index and `reg_wdata` equal to the byte.
- R6: With auto-increment on, the index advances by one modulo 128 after each data byte, whether written or read. With it off, every byte of a burst uses the same index.
- R7: After a read-direction address, the slave shifts out `reg_rdata` at the current index, most significant bit first. A controller acknowledge (SDA low on the ninth clock) requests another byte. A not-acknowledge ends the read with SDA released.
- R8: `sda_oe` changes only while SCL is low, exactly DRIVE_DELAY+3 system clock edges after the SCL pin falls. The 3 edges are two synchronizer stages and one edge-detect stage.
- R9: A START or STOP in the middle of a byte abandons that byte and writes nothing. A START then begins a new address phase.
- R10: While reset is asserted, `sda_oe` and `reg_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_strap | input | 1 | Supplies the strapped bit of the bus address |
| reg_addr | output | 7 | Register index presented to the bank |
| reg_wdata | output | 8 | Write data to the bank |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Read data from the bank at `reg_addr` (combinational) |

## Verification
The bench builds the slave with its defaults: base address 0011100, the strapped bit at position 1 and a drive delay of 4 cycles. The bench drives SCL half periods of about 20 system cycles, so every drive change falls well inside the SCL low phase and its exact edge count can be measured. Both strap levels are used, which brings both bus addresses within reach, as well as the wrong one. Index bytes of 0x7F and 0xFF exercise the fixed index and the wrap from 127 to 0.

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter logic [6:0] BASE_ADDR   = 7'b0011100,
  parameter int         STRAP_POS   = 1,
  parameter int         DRIVE_DELAY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       addr_strap,
  output logic [6:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  localparam int DW = $clog2(DRIVE_DELAY + 1);
  localparam logic [1:0] K_ADDR = 2'd0, K_SUB = 2'd1, K_DATA = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACKW, S_ACK, S_TX, S_MACK, S_ACKR} st_t;

  st_t         state;
  logic [1:0]  kind;
  logic [2:0]  scl_sh, sda_sh;
  logic [2:0]  bitcnt;
  logic [6:0]  shreg, idx;
  logic        inc, rw, drv_next;
  logic [DW-1:0] dly;

  wire scl_s = scl_sh[1];
  wire scl_q = scl_sh[2];
  wire sda_s = sda_sh[1];
  wire sda_q = sda_sh[2];

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  wire [6:0] dev_addr = BASE_ADDR | (7'(addr_strap) << STRAP_POS);
  wire [7:0] rx_byte  = {shreg, sda_s};

  assign reg_addr = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sh    <= 3'b111;
      sda_sh    <= 3'b111;
      state     <= S_IDLE;
      kind      <= K_ADDR;
      bitcnt    <= '0;
      shreg     <= '0;
      idx       <= '0;
      inc       <= 1'b0;
      rw        <= 1'b0;
      drv_next  <= 1'b0;
      dly       <= '0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
      reg_we <= 1'b0;
      if (reg_we && inc) idx <= idx + 7'd1;
      if (dly != '0) begin
        dly <= dly - DW'(1);
        if (dly == DW'(1)) sda_oe <= drv_next;
      end
      if (start_c) begin
        state  <= S_RX;
        kind   <= K_ADDR;
        bitcnt <= '0;
        dly    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= S_IDLE;
        dly    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: ;
          S_RX: if (scl_rise) begin
            shreg  <= rx_byte[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              state <= S_ACKW;
              if (kind == K_ADDR) begin
                rw <= rx_byte[0];
                if (rx_byte[7:1] != dev_addr) state <= S_IDLE;
              end else if (kind == K_SUB) begin
                idx <= rx_byte[6:0];
                inc <= rx_byte[7];
              end else begin
                reg_we    <= 1'b1;
                reg_wdata <= rx_byte;
              end
            end
          end
          S_ACKW: if (scl_fall) begin
            drv_next <= 1'b1;
            dly      <= DW'(DRIVE_DELAY);
            state    <= S_ACK;
          end
          S_ACK: if (scl_fall) begin
            dly    <= DW'(DRIVE_DELAY);
            bitcnt <= '0;
            if (kind == K_ADDR && rw) begin
              shreg    <= reg_rdata[6:0];
              drv_next <= ~reg_rdata[7];
              state    <= S_TX;
            end else begin
              drv_next <= 1'b0;
              state    <= S_RX;
              kind     <= (kind == K_ADDR) ? K_SUB : K_DATA;
            end
          end
          S_TX: if (scl_fall) begin
            dly <= DW'(DRIVE_DELAY);
            if (bitcnt == 3'd7) begin
              drv_next <= 1'b0;
              state    <= S_MACK;
              if (inc) idx <= idx + 7'd1;
            end else begin
              drv_next <= ~shreg[6];
              shreg    <= {shreg[5:0], 1'b0};
              bitcnt   <= bitcnt + 3'd1;
            end
          end
          S_MACK: if (scl_rise) state <= sda_s ? S_IDLE : S_ACKR;
          S_ACKR: if (scl_fall) begin
            shreg    <= reg_rdata[6:0];
            drv_next <= ~reg_rdata[7];
            bitcnt   <= '0;
            dly      <= DW'(DRIVE_DELAY);
            state    <= S_TX;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_oe_rise_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_we_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_stop_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe);

  assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (state == S_RX && bitcnt == 3'd0 && kind == K_ADDR));

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);
endmodule

// File: tb/i2c_regbank_slave_tb.sv
`timescale 1ns/1ps
module i2c_regbank_slave_tb;
  localparam int H = 20;
  localparam int D = 4;

  localparam logic [24:0] VEC [6] = '{
    {1'b0, 8'h85, 8'h3C, 8'hC3},
    {1'b1, 8'h20, 8'h11, 8'h22},
    {1'b0, 8'hFF, 8'hA0, 8'h0B},
    {1'b1, 8'h7F, 8'h5A, 8'h6B},
    {1'b0, 8'h80, 8'h00, 8'hFF},
    {1'b1, 8'hC0, 8'h81, 8'h7E}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic strap = 1'b0;
  logic sda_oe, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] bank [128];
  wire sda_bus = msda & ~sda_oe;

  int checks = 0, fails = 0, wr_count = 0;
  int lowcnt = 0, oe_changes = 0, oe_viol = 0;
  logic prev_oe = 1'b0;

  always #2.5 clk = ~clk;

  i2c_regbank_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_strap(strap), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = bank[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) bank[i] <= 8'(i) ^ 8'h5A;
    end else if (reg_we) begin
      bank[reg_addr] <= reg_wdata;
      wr_count <= wr_count + 1;
    end
    lowcnt <= scl ? 0 : lowcnt + 1;
  end

  // R8 monitor: every drive change must land D+3 edges after the SCL fall
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe) begin
      oe_changes++;
      if (scl !== 1'b0 || lowcnt != D + 3) oe_viol++;
    end
    prev_oe = sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    msda = 1'b1; tick(H); scl = 1'b1; tick(H); msda = 1'b0; tick(H); scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop;
    msda = 1'b0; tick(H); scl = 1'b1; tick(H); msda = 1'b1; tick(H);
  endtask

  task automatic put_bit(input logic b);
    msda = b; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    msda = 1'b1; tick(H); scl = 1'b1; tick(H / 2);
    ack = ~sda_bus;
    tick(H / 2); scl = 1'b0; tick(2);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    msda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl = 1'b1; tick(H / 2);
      b[i] = sda_bus;
      tick(H / 2); scl = 1'b0; tick(2);
    end
    msda = ~mack; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(2); msda = 1'b1;
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic s, k0, k1, k2, k3, k4;
    logic [7:0] sub, d0, d1, e0, e1, r0, r1;
    logic [6:0] a, ix;
    int w0;

    tick(10);
    chk("R10 sda_oe in reset", int'(sda_oe), 0);
    chk("R10 reg_we in reset", int'(reg_we), 0);
    rst_n = 1'b1;
    tick(10);

    for (int v = 0; v < 6; v++) begin
      {s, sub, d0, d1} = VEC[v];
      strap = s;
      tick(5);
      a  = s ? 7'h1E : 7'h1C;
      ix = sub[6:0];
      w0 = wr_count;
      bus_start();
      send_byte({a, 1'b0}, k0);
      send_byte(sub, k1);
      send_byte(d0, k2);
      send_byte(d1, k3);
      bus_stop();
      chk("R3 acks on addr/index/data", int'({k0, k1, k2, k3}), 'hF);
      chk("R5 one strobe per data byte", wr_count - w0, 2);
      if (sub[7]) begin
        e0 = d0; e1 = d1;
        chk("R6 auto-increment write", int'(bank[7'(ix + 7'd1)]), int'(d1));
      end else begin
        e0 = d1; e1 = d1;
      end
      chk("R5 bank at index", int'(bank[ix]), int'(e0));

      bus_start();
      send_byte({a, 1'b0}, k0);
      send_byte(sub, k1);
      bus_start();
      send_byte({a, 1'b1}, k2);
      recv_byte(1'b1, r0);
      recv_byte(1'b0, r1);
      tick(10);
      chk("R7 released after nack", int'(sda_oe), 0);
      bus_stop();
      chk("R4 read setup acks", int'({k0, k1, k2}), 'h7);
      chk("R7 first read byte", int'(r0), int'(e0));
      chk("R6 second read byte", int'(r1), int'(e1));
    end

    // R1: wrong strap level for the address sent
    strap = 1'b0;
    tick(5);
    w0 = wr_count;
    bus_start();
    send_byte({7'h1E, 1'b0}, k0);
    send_byte(8'h10, k1);
    send_byte(8'hEE, k2);
    bus_stop();
    chk("R1 mismatch not acked", int'({k0, k1, k2}), 0);
    chk("R1 mismatch writes nothing", wr_count - w0, 0);

    // R9: START inside a data byte
    w0 = wr_count;
    bus_start();
    send_byte(8'h38, k0);
    send_byte(8'h10, k1);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_start();
    send_byte(8'h38, k2);
    send_byte(8'h12, k3);
    send_byte(8'h99, k4);
    bus_stop();
    chk("R9 new address phase acked", int'({k2, k3, k4}), 'h7);
    chk("R9 aborted byte not written", wr_count - w0, 1);
    chk("R9 bank[10] untouched", int'(bank[7'h10]), int'(8'h10 ^ 8'h5A));
    chk("R9 bank[12] written", int'(bank[7'h12]), 'h99);

    // R9/R2: STOP inside a byte, then a byte with no START
    w0 = wr_count;
    bus_start();
    send_byte(8'h38, k0);
    send_byte(8'h30, k1);
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    bus_stop();
    scl = 1'b0; tick(H);
    send_byte(8'h38, k2);
    send_byte(8'h55, k3);
    bus_stop();
    chk("R2 no ack without START", int'({k2, k3}), 0);
    chk("R9 stop abort writes nothing", wr_count - w0, 0);
    chk("R9 bank[30] untouched", int'(bank[7'h30]), int'(8'h30 ^ 8'h5A));

    tick(20);
    chk("R8 drive timing violations", oe_viol, 0);
    chk("R8 drive changes seen", int'(oe_changes > 0), 1);
    report();
  end
endmodule